// File: doc/BRIEF.md
# Flash Write Guard and Protect Controller

This block owns the status register of a serial flash controller and decides whether each write-type command may run. It keeps the write-enable latch, the busy flag, three protect-level bits, the top/bottom select bit and the status-lock bit. A command decoder in front of it presents one decoded command per cycle, together with the command address, the status data byte and two framing flags. A framing flag reports whether chip select rose on a byte boundary. The other reports whether a status write carried more than one data byte. The controller also sees the level of the write-protect pin.

When a write-type command is allowed, the block sends a one-cycle start pulse and an operation code to the execution engine. It then holds busy for a number of clock cycles set by a parameter for that operation kind. When that count ends, busy drops and write enable clears. Rejected commands change nothing. The protect bits live in plain reset registers.

Top module: `flash_wr_guard`

## Requirements
- R1: After reset, status_o reads 8'h00, pd_o is 0 and start_o is 0.
- R2: cmd_i is sampled when cmd_vld_i is 1, with these codes: 1 write enable, 2 write disable, 3 status write, 4 page program, 5 small sector erase, 6 sector erase, 7 chip erase, 8 power down, 9 power-down exit. Write enable sets status bit 1 and write disable clears it, when the block is neither busy nor powered down. status_o puts busy at bit 0, write enable at bit 1, protect level bits 4:2, top/bottom select at bit 5, 0 at bit 6 and the status lock at bit 7.
- R3: A write-type command (codes 3 to 7) starts only when write enable is 1, the block is not busy and not powered down, and aligned_i is 1. On a start, start_o is 1 for exactly the cycle after the command, and op_o carries 1 for status write, 2 for page program, 3 for small sector erase, 4 for sector erase or 5 for chip erase.
- R4: Write enable clears in the same cycle that busy falls at the end of a started operation. A rejected write-type command leaves it unchanged.
- R5: With level bits 000 nothing is protected. With bit 4 set, the whole array is protected. Otherwise, level 01, 10 or 11 protects the top 1/8, 1/4 or 1/2 of the address space when bit 5 is 0, and the bottom part when bit 5 is 1. Program and sector-type erases whose address falls in the protected region are rejected.
- R6: Chip erase starts only when nothing is protected.
- R7: Status write is rejected when bit 7 is 1 and wp_i is 0, and also when extra_i is 1. When it starts, bits 7 and 5:2 take sr_data_i. Bits 1:0 and 6 are not written from the data byte.
- R8: Busy stays high for exactly the parameter cycle count of the started operation, counted from the cycle after the command.
- R9: Power down is ignored while busy. While powered down, every command except the exit is ignored, and the exit clears pd_o.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cmd_vld_i | input | 1 | Decoded command present this cycle |
| cmd_i | input | 4 | Command code |
| addr_i | input | AW | Command address |
| sr_data_i | input | 8 | Status write data byte |
| aligned_i | input | 1 | Chip select rose on a byte boundary |
| extra_i | input | 1 | Status write carried more than one data byte |
| wp_i | input | 1 | Write-protect pin level |
| start_o | output | 1 | One-cycle start to the execution engine |
| op_o | output | 3 | Operation kind on start |
| status_o | output | 8 | Status register |
| pd_o | output | 1 | Power-down state |

## Verification
The assertions assume that the decoder only raises cmd_vld_i for one cycle per chip-select rise. They also assume that cmd_i carries a listed code whenever valid is high, and that every busy parameter is at least 1. The bench drives each command as a single-cycle valid pulse with a listed code, on the falling clock edge. It keeps wp_i steady across each command. It also sets the protect bits only through accepted status writes, so the protect decode always sees a state that the block itself reached.

// File: rtl/wpc_pkg.sv
package wpc_pkg;
  typedef enum logic [3:0] {
    CMD_NONE = 4'd0, CMD_WREN = 4'd1, CMD_WRDI = 4'd2, CMD_WRSR = 4'd3,
    CMD_PP   = 4'd4, CMD_SSE  = 4'd5, CMD_SE   = 4'd6, CMD_CE   = 4'd7,
    CMD_PD   = 4'd8, CMD_EXIT = 4'd9
  } cmd_e;

  typedef enum logic [2:0] {
    OP_NONE = 3'd0, OP_SR = 3'd1, OP_PP = 3'd2, OP_SSE = 3'd3,
    OP_SE = 3'd4, OP_CE = 3'd5
  } op_e;
endpackage

// File: rtl/wpc_prot_decode.sv
module wpc_prot_decode #(
  parameter int AW = 19
) (
  input  logic [AW-1:0] addr_i,
  input  logic [2:0]    lvl_i,
  input  logic          bot_i,
  output logic          hit_o,
  output logic          any_o
);
  always_comb begin
    int k;
    any_o = lvl_i[2] | (lvl_i[1:0] != 2'b00);
    k     = AW - 4 + int'(lvl_i[1:0]);
    if (lvl_i[2]) begin
      hit_o = 1'b1;
    end else if (lvl_i[1:0] == 2'b00) begin
      hit_o = 1'b0;
    end else begin
      // region = all high bits above k equal 1 (top) or 0 (bottom)
      hit_o = 1'b1;
      for (int i = 0; i < AW; i++)
        if (i >= k && addr_i[i] == bot_i) hit_o = 1'b0;
    end
  end
endmodule

// File: rtl/wpc_busy_timer.sv
module wpc_busy_timer #(
  parameter int CNT_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_i,
  input  logic [CNT_W-1:0] dur_i,
  output logic             busy_o,
  output logic             done_o
);
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)            cnt_q <= '0;
    else if (load_i)        cnt_q <= dur_i;
    else if (cnt_q != '0)   cnt_q <= cnt_q - 1'b1;
  end

  assign busy_o = (cnt_q != '0);
  assign done_o = (cnt_q == CNT_W'(1));

  // R8
  load_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_i |-> !busy_o);
  // R8
  load_busy_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_i |=> busy_o);
endmodule

// File: rtl/flash_wr_guard.sv
module flash_wr_guard
  import wpc_pkg::*;
#(
  parameter int AW    = 19,
  parameter int CNT_W = 16,
  parameter int T_SR  = 8,
  parameter int T_PP  = 12,
  parameter int T_SSE = 20,
  parameter int T_SE  = 30,
  parameter int T_CE  = 50
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          cmd_vld_i,
  input  logic [3:0]    cmd_i,
  input  logic [AW-1:0] addr_i,
  input  logic [7:0]    sr_data_i,
  input  logic          aligned_i,
  input  logic          extra_i,
  input  logic          wp_i,
  output logic          start_o,
  output logic [2:0]    op_o,
  output logic [7:0]    status_o,
  output logic          pd_o
);
  logic       wen_q, srl_q, bot_q, pd_q, start_q;
  logic [2:0] lvl_q;
  op_e        op_q, kind;
  logic       busy, done, hit, any_prot, blocked, go, idle_cmd;
  logic [CNT_W-1:0] dur;

  wpc_prot_decode #(.AW(AW)) u_prot (
    .addr_i(addr_i), .lvl_i(lvl_q), .bot_i(bot_q), .hit_o(hit), .any_o(any_prot)
  );

  wpc_busy_timer #(.CNT_W(CNT_W)) u_tmr (
    .clk_i(clk_i), .rst_ni(rst_ni), .load_i(go), .dur_i(dur),
    .busy_o(busy), .done_o(done)
  );

  always_comb begin
    kind    = OP_NONE;
    blocked = 1'b0;
    dur     = '0;
    unique case (cmd_e'(cmd_i))
      CMD_WRSR: begin kind = OP_SR;  blocked = extra_i | (srl_q & ~wp_i); dur = CNT_W'(T_SR);  end
      CMD_PP:   begin kind = OP_PP;  blocked = hit;      dur = CNT_W'(T_PP);  end
      CMD_SSE:  begin kind = OP_SSE; blocked = hit;      dur = CNT_W'(T_SSE); end
      CMD_SE:   begin kind = OP_SE;  blocked = hit;      dur = CNT_W'(T_SE);  end
      CMD_CE:   begin kind = OP_CE;  blocked = any_prot; dur = CNT_W'(T_CE);  end
      default:  ;
    endcase
  end

  assign idle_cmd = cmd_vld_i & ~busy & ~pd_q;
  assign go = idle_cmd & (kind != OP_NONE) & aligned_i & wen_q & ~blocked;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wen_q <= 1'b0; srl_q <= 1'b0; bot_q <= 1'b0; lvl_q <= '0;
      pd_q <= 1'b0; start_q <= 1'b0; op_q <= OP_NONE;
    end else begin
      start_q <= go;
      op_q    <= go ? kind : OP_NONE;
      if (done)
        wen_q <= 1'b0;
      else if (idle_cmd && cmd_i == CMD_WREN)
        wen_q <= 1'b1;
      else if (idle_cmd && cmd_i == CMD_WRDI)
        wen_q <= 1'b0;
      if (go && kind == OP_SR) begin
        srl_q <= sr_data_i[7];
        bot_q <= sr_data_i[5];
        lvl_q <= sr_data_i[4:2];
      end
      if (idle_cmd && cmd_i == CMD_PD)
        pd_q <= 1'b1;
      else if (cmd_vld_i && pd_q && cmd_i == CMD_EXIT)
        pd_q <= 1'b0;
    end
  end

  assign start_o  = start_q;
  assign op_o     = op_q;
  assign pd_o     = pd_q;
  assign status_o = {srl_q, 1'b0, bot_q, lvl_q, wen_q, busy};

  // R3
  start_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_o |-> $past(!busy && !pd_q && wen_q));
  // R7
  sr_lock_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start_o && op_o == OP_SR) |-> $past(wp_i || !srl_q));
  // R6
  ce_open_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start_o && op_o == OP_CE) |-> $past(lvl_q == 3'b000));
  // R4
  wen_fall_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(wen_q) |-> $past(done || (cmd_vld_i && cmd_i == CMD_WRDI)));
  // R9
  pd_rise_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(pd_q) |-> $past(!busy));
endmodule

// File: tb/sim_flash_wr_guard.sv
`timescale 1ns/1ps
module sim_flash_wr_guard;
  localparam int AW = 19;
  localparam int T_SR = 3, T_PP = 4, T_SSE = 5, T_SE = 6, T_CE = 7;

  logic clk = 1'b0, rst_n = 1'b0;
  logic cmd_vld = 1'b0, aligned = 1'b1, extra = 1'b0, wp = 1'b1;
  logic [3:0] cmd = '0;
  logic [AW-1:0] addr = '0;
  logic [7:0] sr_data = '0;
  logic start, pd;
  logic [2:0] op;
  logic [7:0] status;
  int errors = 0, checks = 0;

  always #2 clk = ~clk;

  flash_wr_guard #(.AW(AW), .CNT_W(8), .T_SR(T_SR), .T_PP(T_PP),
                   .T_SSE(T_SSE), .T_SE(T_SE), .T_CE(T_CE)) u0 (
    .clk_i(clk), .rst_ni(rst_n), .cmd_vld_i(cmd_vld), .cmd_i(cmd),
    .addr_i(addr), .sr_data_i(sr_data), .aligned_i(aligned), .extra_i(extra),
    .wp_i(wp), .start_o(start), .op_o(op), .status_o(status), .pd_o(pd)
  );

  // {tb, lvl[2:0]} , cmd, addr, expected start
  localparam int NV = 13;
  localparam logic [27:0] VEC [NV] = '{
    {4'b0001, 4'd4, 19'h70000, 1'b0}, {4'b0001, 4'd4, 19'h6FFFF, 1'b1},
    {4'b0010, 4'd5, 19'h60000, 1'b0}, {4'b0010, 4'd5, 19'h5FFFF, 1'b1},
    {4'b0011, 4'd6, 19'h40000, 1'b0}, {4'b0011, 4'd6, 19'h3FFFF, 1'b1},
    {4'b1001, 4'd4, 19'h0FFFF, 1'b0}, {4'b1001, 4'd4, 19'h10000, 1'b1},
    {4'b1011, 4'd5, 19'h3FFFF, 1'b0}, {4'b1011, 4'd5, 19'h40000, 1'b1},
    {4'b0100, 4'd4, 19'h00000, 1'b0}, {4'b0001, 4'd7, 19'h00000, 1'b0},
    {4'b1000, 4'd7, 19'h00000, 1'b1}
  };

  task automatic check(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic issue(input logic [3:0] c, input logic [AW-1:0] a,
                       input logic [7:0] d, input logic al, input logic ex);
    @(negedge clk);
    cmd_vld = 1'b1; cmd = c; addr = a; sr_data = d; aligned = al; extra = ex;
    @(negedge clk);
    cmd_vld = 1'b0; aligned = 1'b1; extra = 1'b0;
  endtask

  task automatic wait_idle();
    while (status[0]) @(negedge clk);
  endtask

  task automatic set_prot(input logic [3:0] p);
    issue(4'd1, '0, 8'h00, 1'b1, 1'b0);
    issue(4'd3, '0, {2'b00, p, 2'b00}, 1'b1, 1'b0);
    wait_idle();
  endtask

  task automatic finish_run();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    int n;
    repeat (3) @(negedge clk);
    // R1 reset state
    check("R1 status", status, 8'h00);
    check("R1 pd", pd, 0);
    check("R1 start", start, 0);
    rst_n = 1'b1;
    @(negedge clk);

    // R2 set / clear write enable
    issue(4'd1, '0, 8'h00, 1'b1, 1'b0);
    check("R2 wren", status, 8'h02);
    issue(4'd2, '0, 8'h00, 1'b1, 1'b0);
    check("R2 wrdi", status, 8'h00);

    // R3 program without write enable
    issue(4'd4, '0, 8'h00, 1'b1, 1'b0);
    check("R3 no wen start", start, 0);

    // R7 status write of all ones: bit 6 and bits 1:0 not from data
    issue(4'd1, '0, 8'h00, 1'b1, 1'b0);
    issue(4'd3, '0, 8'hFF, 1'b1, 1'b0);
    check("R3 sr start", start, 1);
    check("R3 sr op", op, 1);
    check("R7 sr busy view", status, 8'hBF);
    wait_idle();
    check("R4 sr wen clear", status, 8'hBC);

    // R7 lock with pin low
    wp = 1'b0;
    issue(4'd1, '0, 8'h00, 1'b1, 1'b0);
    issue(4'd3, '0, 8'h00, 1'b1, 1'b0);
    check("R7 locked start", start, 0);
    check("R7 locked status", status, 8'hBE);
    wp = 1'b1;
    issue(4'd3, '0, 8'h00, 1'b1, 1'b0);
    check("R7 unlocked start", start, 1);
    wait_idle();
    check("R7 unlocked status", status, 8'h00);

    // R7 overrun rejected
    issue(4'd1, '0, 8'h00, 1'b1, 1'b0);
    issue(4'd3, '0, 8'h04, 1'b1, 1'b1);
    check("R7 overrun start", start, 0);
    check("R7 overrun status", status, 8'h02);

    // R3 misaligned chip select
    issue(4'd4, '0, 8'h00, 1'b0, 1'b0);
    check("R3 misaligned start", start, 0);
    check("R4 misaligned wen kept", status, 8'h02);

    // R5 R6 protect table
    for (int i = 0; i < NV; i++) begin
      logic [27:0] v;
      v = VEC[i];
      set_prot(v[27:24]);
      issue(4'd1, '0, 8'h00, 1'b1, 1'b0);
      issue(v[23:20], v[19:1], 8'h00, 1'b1, 1'b0);
      check($sformatf("R5 R6 row %0d start", i), start, v[0]);
      if (v[0]) check($sformatf("R3 row %0d op", i), op, int'(v[23:20]) - 2);
      wait_idle();
      check($sformatf("R4 row %0d wen", i), status[1], !v[0]);
    end
    set_prot(4'b0000);

    // R8 sector erase busy length, R4 wen clears with busy
    issue(4'd1, '0, 8'h00, 1'b1, 1'b0);
    issue(4'd6, '0, 8'h00, 1'b1, 1'b0);
    n = 0;
    while (status[0]) begin n++; @(negedge clk); end
    check("R8 busy cycles", n, T_SE);
    check("R4 end status", status, 8'h00);

    // R3 R9 commands while busy
    issue(4'd1, '0, 8'h00, 1'b1, 1'b0);
    issue(4'd4, '0, 8'h00, 1'b1, 1'b0);
    issue(4'd4, '0, 8'h00, 1'b1, 1'b0);
    check("R3 busy reject", start, 0);
    issue(4'd8, '0, 8'h00, 1'b1, 1'b0);
    check("R9 pd while busy", pd, 0);
    wait_idle();

    // R9 power down
    issue(4'd8, '0, 8'h00, 1'b1, 1'b0);
    check("R9 pd entry", pd, 1);
    issue(4'd1, '0, 8'h00, 1'b1, 1'b0);
    check("R9 wren ignored", status, 8'h00);
    issue(4'd9, '0, 8'h00, 1'b1, 1'b0);
    check("R9 exit", pd, 0);
    issue(4'd1, '0, 8'h00, 1'b1, 1'b0);
    check("R2 wren after exit", status, 8'h02);

    finish_run();
  end
endmodule